// File: doc/BRIEF.md
# Training-Word Frame Lock Receiver

This block sits on the receive side of a serial optical link and runs on the bit clock that an upstream clock-recovery stage produces. Each cycle it takes one received bit. It searches the bit stream for the 8-bit training word `10100101`. Once it has seen that word sixteen times in a row, each one exactly eight bits after the previous one, it declares lock. It then runs a free-running frame marker with an 8-bit period, aligned to the word boundaries it found. While locked it ignores any later occurrence of the training word, so payload that happens to contain the pattern cannot move the frame phase.

The block also watches for a long run of zeros, which is what a blocked or broken optical path looks like. After 4096 consecutive zero bits it drops lock and raises a link-lost flag. It holds that flag until a one bit arrives, and it then starts hunting for training words again from a count of zero. A feedback bit for the transmitter is high whenever the receiver is not locked. While this bit is high the far end keeps sending training words.

The controller has three states. In HUNT it is collecting aligned detections. In LOCKED the frame marker is running. In LOST the zero run has reached its limit. There are four transitions:
- QUALIFY (HUNT→LOCKED): the sixteenth aligned detection.
- DROP_HUNT (HUNT→LOST): the zero run reaches 4096.
- DROP_LOCK (LOCKED→LOST): the zero run reaches 4096.
- RECOVER (LOST→HUNT): any one bit is received.

Top module: `frame_lock_rx`

## Requirements
- R1: A synchronous active-high reset sets the state to HUNT. In the first cycle after reset, `locked`=0, `link_lost`=0, `frame_sync`=0 and `train_req`=1.
- R2: Bits enter the MSB of an 8-bit window first, so the first bit received ends up at bit 7. A detection is a window equal to 8'b10100101. A detection adds to the qualification count only when it comes exactly 8 bits after the previous counted detection. A detection at any other spacing restarts the count at 1. If 8 bits pass after a detection without another detection, the count clears to 0.
- R3: `locked` rises in the cycle after the one in which the 16th qualifying detection is in the window. With fewer qualifying detections it stays low.
- R4: While locked, `frame_sync` is a one-cycle pulse every 8 cycles. It is high in the cycle after the last bit of each frame-aligned word has been shifted in. The first pulse comes 8 cycles after the qualifying detection.
- R5: While locked, detections at any phase change neither `locked` nor the phase of `frame_sync`.
- R6: In HUNT or LOCKED, the 4096th consecutive zero bit moves the state to LOST. In the next cycle `link_lost`=1 and `locked`=0, and `frame_sync` stops. After 4095 zeros nothing has changed.
- R7: A run of zeros broken by a one before it reaches 4096 bits never sets `link_lost`.
- R8: `link_lost` stays high while zeros keep arriving; the zero counter saturates and does not wrap.
- R9: A received one clears `link_lost` in the next cycle and returns the block to HUNT with the count at zero. Lock then needs 16 new qualifying detections.
- R10: `train_req` is high in every cycle in which the block is not locked, including while the link is lost. It is low while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_bit | input | 1 | Received serial data bit |
| frame_sync | output | 1 | One-cycle frame boundary pulse while locked |
| locked | output | 1 | Frame lock acquired |
| link_lost | output | 1 | Zero run has reached the loss limit |
| train_req | output | 1 | Feedback to the transmitter: send training words |

## Verification
The checker watches the following on every cycle:
- `frame_sync` keeps its 8-cycle spacing and only occurs while locked.
- Lock only rises after a detection, and only falls together with link loss.
- A received one always clears the loss flag, and continued zeros keep it set.

The exact cycle of lock after the 16th word, the clearing of the count by a missing word or a mis-spaced match, and the frame phase staying fixed across payload and mis-aligned patterns can only be shown by the bench's scenarios. The same holds for the 4095/4096 loss boundary, a zero run broken one bit short of the limit, and reacquisition after loss.

// File: rtl/frame_lock_pkg.sv
package frame_lock_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_LOCKED = 2'd1,
        ST_LOST   = 2'd2
    } lock_state_t;
endpackage

// File: rtl/fl_word_detect.sv
module fl_word_detect #(
    parameter int          WORD_W  = 8,
    parameter logic [WORD_W-1:0] PATTERN = 8'hA5
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic hit
);
    logic [WORD_W-1:0] window_q;

    always_ff @(posedge clk) begin
        if (rst) window_q <= '0;
        else     window_q <= {window_q[WORD_W-2:0], bit_in};
    end

    always_comb hit = (window_q == PATTERN);
endmodule

// File: rtl/fl_zero_watch.sv
module fl_zero_watch #(
    parameter int LOSS_RUN = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic run_done
);
    localparam int ZW = $clog2(LOSS_RUN + 1);
    localparam logic [ZW-1:0] LIMIT   = ZW'(LOSS_RUN);
    localparam logic [ZW-1:0] LIMIT_M = ZW'(LOSS_RUN - 1);

    logic [ZW-1:0] zrun_q;

    always_ff @(posedge clk) begin
        if (rst)                  zrun_q <= '0;
        else if (bit_in)          zrun_q <= '0;
        else if (zrun_q != LIMIT) zrun_q <= zrun_q + 1'b1;
    end

    // The edge that takes this zero in makes the run reach the limit.
    always_comb run_done = !bit_in && (zrun_q == LIMIT_M);
endmodule

// File: rtl/fl_frame_gen.sv
module fl_frame_gen #(
    parameter int WORD_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic active,
    input  logic keep,
    output logic pulse
);
    localparam int FW = $clog2(WORD_W);
    localparam logic [FW-1:0] LAST  = FW'(WORD_W - 1);
    localparam logic [FW-1:0] EARLY = FW'(WORD_W - 2);

    logic [FW-1:0] phase_q;
    logic          early;
    logic          pulse_q;

    always_ff @(posedge clk) begin
        if (rst || load)     phase_q <= '0;
        else if (active)     phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end

    // Marker generated one bit ahead, then aligned by a single flop.
    always_comb early = active && (phase_q == EARLY);

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= early && keep;
    end

    always_comb pulse = pulse_q;
endmodule

// File: rtl/frame_lock_rx.sv
module frame_lock_rx
    import frame_lock_pkg::*;
#(
    parameter int          WORD_W     = 8,
    parameter logic [WORD_W-1:0] PATTERN = 8'hA5,
    parameter int          QUAL_COUNT = 16,
    parameter int          LOSS_RUN   = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_bit,
    output logic frame_sync,
    output logic locked,
    output logic link_lost,
    output logic train_req
);
    localparam int QW = (QUAL_COUNT > 2) ? $clog2(QUAL_COUNT) : 1;
    localparam int GW = $clog2(WORD_W);
    localparam logic [QW-1:0] QUAL_LAST = QW'(QUAL_COUNT - 1);
    localparam logic [GW-1:0] GAP_LAST  = GW'(WORD_W - 1);

    lock_state_t   state, state_n;
    logic          det_hit;
    logic          loss_evt;
    logic          aligned;
    logic          acquire;
    logic [QW-1:0] qcnt_q;
    logic [GW-1:0] gap_q;

    fl_word_detect #(.WORD_W(WORD_W), .PATTERN(PATTERN)) u_detect (
        .clk(clk), .rst(rst), .bit_in(rx_bit), .hit(det_hit)
    );

    fl_zero_watch #(.LOSS_RUN(LOSS_RUN)) u_zero (
        .clk(clk), .rst(rst), .bit_in(rx_bit), .run_done(loss_evt)
    );

    fl_frame_gen #(.WORD_W(WORD_W)) u_frame (
        .clk(clk), .rst(rst), .load(acquire),
        .active(state == ST_LOCKED), .keep(state_n == ST_LOCKED),
        .pulse(frame_sync)
    );

    always_comb aligned = (qcnt_q == '0) || (gap_q == GAP_LAST);

    // Next-state logic
    always_comb begin
        state_n = state;
        acquire = 1'b0;
        unique case (state)
            ST_HUNT: begin
                if (loss_evt) begin
                    state_n = ST_LOST;                         // DROP_HUNT
                end else if (det_hit && aligned && qcnt_q == QUAL_LAST) begin
                    state_n = ST_LOCKED;                       // QUALIFY
                    acquire = 1'b1;
                end
            end
            ST_LOCKED: if (loss_evt) state_n = ST_LOST;        // DROP_LOCK
            ST_LOST:   if (rx_bit)   state_n = ST_HUNT;        // RECOVER
            default:   state_n = ST_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_HUNT;
        else     state <= state_n;
    end

    // Qualification counter: only advances while hunting
    always_ff @(posedge clk) begin
        if (rst || state != ST_HUNT) begin
            qcnt_q <= '0;
            gap_q  <= '0;
        end else if (det_hit) begin
            gap_q  <= '0;
            qcnt_q <= aligned ? qcnt_q + 1'b1 : QW'(1);
        end else begin
            gap_q <= (gap_q == GAP_LAST) ? '0 : gap_q + 1'b1;
            if (gap_q == GAP_LAST) qcnt_q <= '0;
        end
    end

    // Outputs
    always_comb begin
        locked    = (state == ST_LOCKED);
        link_lost = (state == ST_LOST);
        train_req = (state != ST_LOCKED);
    end
endmodule

// File: rtl/fl_checker.sv
module fl_checker #(
    parameter int WORD_W = 8
) (
    input logic clk,
    input logic rst,
    input logic rx_bit,
    input logic det_hit,
    input logic locked,
    input logic link_lost,
    input logic frame_sync,
    input logic train_req
);
    logic [15:0] fs_gap;
    logic        fs_seen;

    always_ff @(posedge clk) begin
        if (rst || !locked) begin
            fs_gap  <= '0;
            fs_seen <= 1'b0;
        end else if (frame_sync) begin
            fs_gap  <= '0;
            fs_seen <= 1'b1;
        end else if (fs_gap != 16'hFFFF) begin
            fs_gap  <= fs_gap + 1'b1;
        end
    end

    p_fs_period_r4: assert property (@(posedge clk) disable iff (rst)
        (frame_sync && fs_seen) |-> (fs_gap == 16'(WORD_W - 1)));

    p_fs_when_locked_r4: assert property (@(posedge clk) disable iff (rst)
        frame_sync |-> locked);

    p_lock_after_match_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(det_hit));

    p_lock_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> link_lost);

    p_loss_on_zero_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(link_lost) |-> !$past(rx_bit));

    p_loss_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (link_lost && !rx_bit) |=> link_lost);

    p_one_clears_r9: assert property (@(posedge clk) disable iff (rst)
        rx_bit |=> !link_lost);

    p_feedback_r10: assert property (@(posedge clk) disable iff (rst)
        link_lost |-> (train_req && !locked));
endmodule

bind frame_lock_rx fl_checker #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .det_hit(det_hit),
    .locked(locked), .link_lost(link_lost),
    .frame_sync(frame_sync), .train_req(train_req)
);

// File: tb/frame_lock_rx_tb.sv
`timescale 1ns/1ps
module frame_lock_rx_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_bit = 1'b0;
    logic frame_sync, locked, link_lost, train_req;

    int n_checks = 0;
    int n_fail   = 0;
    int n_after  = 0;

    localparam logic [7:0] TRAIN = 8'hA5;

    always #2.5 clk = ~clk;

    frame_lock_rx u_dut (
        .clk(clk), .rst(rst), .rx_bit(rx_bit),
        .frame_sync(frame_sync), .locked(locked),
        .link_lost(link_lost), .train_req(train_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rx_bit = b;
        @(posedge clk);
        #1;
    endtask

    task automatic send_bits(input logic [31:0] v, input int cnt);
        for (int i = cnt - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_words(input int cnt);
        for (int i = 0; i < cnt; i++) send_bits(32'(TRAIN), 8);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rx_bit = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    // Bit sent after acquisition with frame-phase check (R4) and lock hold (R5)
    task automatic send_track(input logic b);
        send_bit(b);
        n_after++;
        chk("R4 frame_sync phase", int'(frame_sync), (n_after % 8 == 0) ? 1 : 0);
        chk("R5 locked held", int'(locked), 1);
    endtask

    task automatic track_bits(input logic [31:0] v, input int cnt);
        for (int i = cnt - 1; i >= 0; i--) send_track(v[i]);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #1000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 locked", int'(locked), 0);
        chk("R1 link_lost", int'(link_lost), 0);
        chk("R1 frame_sync", int'(frame_sync), 0);
        chk("R1 train_req", int'(train_req), 1);

        // R3: sweep of word counts, lock only at 16
        for (int n = 1; n <= 16; n++) begin
            do_reset();
            send_words(n);
            chk("R3 not yet at word end", int'(locked), 0);
            send_bit(1'b0);
            chk("R3 lock vs word count", int'(locked), (n == 16) ? 1 : 0);
            chk("R10 train_req vs lock", int'(train_req), (n == 16) ? 0 : 1);
        end

        // R2: a missing word (16-bit spacing) clears the count
        do_reset();
        send_words(10);
        send_bits(32'hFF, 8);
        send_words(15);
        send_bit(1'b1);
        chk("R2 count cleared by missing word", int'(locked), 0);
        send_bits(32'h25, 7);
        send_bit(1'b0);
        chk("R2 lock after 16 fresh words", int'(locked), 1);

        // R2: an overlapping match at spacing 5 restarts the count at 1
        do_reset();
        send_words(15);
        send_bits(32'h05, 5);
        send_bit(1'b1);
        chk("R2 mis-spaced match restarts", int'(locked), 0);
        send_bits(32'h25, 7);
        send_words(13);
        send_bit(1'b1);
        chk("R2 restart count at 15", int'(locked), 0);
        send_bits(32'h25, 7);
        send_bit(1'b0);
        chk("R2 restart count reaches 16", int'(locked), 1);

        // R4/R5: frame phase over training words, payload and a mis-aligned pattern
        do_reset();
        send_words(16);
        chk("R3 still low in qualifying cycle", int'(locked), 0);
        n_after = 0;
        for (int w = 0; w < 4; w++) track_bits(32'(TRAIN), 8);
        for (int k = 0; k < 12; k++) track_bits(32'((k * 37 + 11) & 255), 8);
        track_bits(32'h3, 3);
        track_bits(32'(TRAIN), 8);
        track_bits(32'h19, 5);
        for (int w = 0; w < 2; w++) track_bits(32'(TRAIN), 8);

        // R6: loss boundary from LOCKED
        send_bit(1'b1);
        repeat (4095) send_bit(1'b0);
        chk("R6 no loss at 4095 zeros", int'(link_lost), 0);
        chk("R6 still locked at 4095 zeros", int'(locked), 1);
        send_bit(1'b0);
        chk("R6 loss at 4096 zeros", int'(link_lost), 1);
        chk("R6 lock dropped", int'(locked), 0);
        chk("R10 train_req while lost", int'(train_req), 1);
        repeat (100) begin
            send_bit(1'b0);
            chk("R6 frame_sync stopped", int'(frame_sync), 0);
        end
        chk("R8 loss held under more zeros", int'(link_lost), 1);

        // R9: a one clears the flag
        send_bit(1'b1);
        chk("R9 one clears link_lost", int'(link_lost), 0);
        chk("R9 back to hunting", int'(locked), 0);
        chk("R10 train_req while hunting", int'(train_req), 1);

        // R7: run broken one bit short of the limit
        repeat (4095) send_bit(1'b0);
        send_bit(1'b1);
        repeat (4095) send_bit(1'b0);
        chk("R7 broken zero run", int'(link_lost), 0);

        // R9: reacquisition needs 16 fresh words
        send_words(15);
        send_bit(1'b1);
        chk("R9 15 words after loss", int'(locked), 0);
        send_bits(32'h25, 7);
        send_bit(1'b0);
        chk("R9 relock after 16 words", int'(locked), 1);
        chk("R10 train_req low when locked", int'(train_req), 0);

        // R1: reset while locked
        do_reset();
        chk("R1 locked after reset", int'(locked), 0);
        chk("R1 train_req after reset", int'(train_req), 1);

        // R6: loss from HUNT
        repeat (4096) send_bit(1'b0);
        chk("R6 loss while hunting", int'(link_lost), 1);
        chk("R10 train_req on loss from hunt", int'(train_req), 1);

        finish_run();
    end
endmodule